// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is a byte-oriented SPI master that runs one burst of bytes per start command. Software fills an internal transmit FIFO through a word-addressed register port, programs how many bytes the burst lasts and how many of them come from the transmit FIFO, then sets the start bit. The shift engine clocks each byte out on MOSI and captures the byte arriving on MISO into an internal receive FIFO. Once the transmit budget is spent, the remaining bytes of the burst go out as 0x00 and leave the transmit FIFO untouched. The serial clock rate is set outside: the block advances one half-period of SCK for each `sck_tick` pulse.

Clock polarity, clock phase, bit order, which of four chip-select lines is used, its active level and a manual override are all control bits. A discard option keeps a transmit-only burst out of the receive FIFO. The end of a burst and a receive overflow each set a write-one-to-clear status flag. Each flag can drive `irq_o` when its enable bit is set.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, `sck_o` is 0, all four `cs_o` lines are 1, `irq_o` is 0, and the control (word 0), status (word 2) and FIFO status (word 4) registers read 0.
- R2: Writing control word 0 with bit 31 set while idle starts a burst. Bit 31 reads 1 while the burst runs and clears by itself after the last byte. The burst length in bytes is the 24-bit register at word 5, and a length of 0 completes at once.
- R3: Control bit 1 sets the idle level of SCK. With bit 0 clear, each bit is on MOSI before the leading SCK edge and MISO is sampled on the leading edge. With bit 0 set, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Each received byte is written to the receive FIFO.
- R4: Control bit 12 set shifts the least significant bit first in both directions. Bit 12 clear shifts the most significant bit first.
- R5: Only the first N bytes of a burst are popped from the transmit FIFO, where N is the 24-bit register at word 6. Later bytes are sent as 0x00 and leave the FIFO unchanged. Word 7 holds a 24-bit single-mode transmit count that reads back as written.
- R6: With control bit 8 set, the bytes received during the burst are not written to the receive FIFO.
- R7: Status bit 12 is set when a burst completes. `irq_o` is the OR of the status bits ANDed with the enable register at word 1. Writing 1 to a status bit clears it, and writing all ones clears every flag.
- R8: A byte received while the receive FIFO is full and bit 8 is clear is dropped, and status bit 8 is set.
- R9: Writing word 3 with bit 15 set empties the receive FIFO, and with bit 31 set empties the transmit FIFO. Word 4 reports the receive fill count in bits [7:0] and the transmit fill count in bits [23:16]; a full FIFO of 128 reads as 128. A write to word 8 pushes a byte. A read of word 9 with `reg_re` returns the head byte and pops it.
- R10: Control bits [5:4] choose one of the four chip-select lines, and bit 2 gives its active level (1 = active high). Without manual mode, the chosen line is active only while a burst runs. With bit 6 set, the chosen line is driven with the level in bit 7. Unchosen lines always sit at the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive FIFO at word 9) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sck_tick | input | 1 | SCK half-period enable |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_o | output | 4 | Chip-select lines |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench loops MOSI back to MISO and decodes the wire with a monitor that samples on the edge the programmed phase calls for. This separates a wrong sampling edge or a reversed bit order from a correct round trip, which a loopback alone would hide.

Random bursts cover all four clock modes, both bit orders, every chip-select index and level, and transmit counts from zero to the full burst. Spare bytes are left in the transmit FIFO, so the leftover fill count shows whether pops stopped at the budget. Directed cases check the following:
- a burst longer than the receive FIFO, to confirm the overflow flag and the 128 count;
- a transmit FIFO filled past its depth;
- a masked completion interrupt;
- manual chip-select levels.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  localparam int unsigned PH_W   = IDX_W + 1;

  // word addresses of the register port
  localparam logic [3:0] A_CTL  = 4'd0;
  localparam logic [3:0] A_IEN  = 4'd1;
  localparam logic [3:0] A_STA  = 4'd2;
  localparam logic [3:0] A_FCTL = 4'd3;
  localparam logic [3:0] A_FSTA = 4'd4;
  localparam logic [3:0] A_BLEN = 4'd5;
  localparam logic [3:0] A_TLEN = 4'd6;
  localparam logic [3:0] A_SLEN = 4'd7;
  localparam logic [3:0] A_TXD  = 4'd8;
  localparam logic [3:0] A_RXD  = 4'd9;

  // control word bit positions
  localparam int unsigned B_CPHA  = 0;
  localparam int unsigned B_CPOL  = 1;
  localparam int unsigned B_ACTHI = 2;
  localparam int unsigned B_CSIDX = 4;
  localparam int unsigned B_CSMAN = 6;
  localparam int unsigned B_CSLVL = 7;
  localparam int unsigned B_DISC  = 8;
  localparam int unsigned B_LSB   = 12;
  localparam int unsigned B_GO    = 31;

  // status / enable bits and FIFO control bits
  localparam int unsigned B_OVF   = 8;
  localparam int unsigned B_DONE  = 12;
  localparam int unsigned B_RXRST = 15;
  localparam int unsigned B_TXRST = 31;
  localparam int unsigned B_TXFIL = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RUN, ST_FIN, ST_DONE
  } eng_state_t;

  // position on the byte of the idx-th bit on the wire
  function automatic logic [IDX_W-1:0] wire_bit(input logic lsb_first,
                                                input logic [IDX_W-1:0] idx);
    return lsb_first ? idx : IDX_W'(BYTE_W - 1) - idx;
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R9
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              discard,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              tick,
  input  logic              tx_empty,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              busy,
  output logic              burst_done,
  output logic              ovf_evt
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(2 * BYTE_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  byte_cnt, tx_taken;
  logic [BYTE_W-1:0] txb, rxb, next_byte;
  logic [PH_W-1:0]   phase;
  logic [IDX_W-1:0]  cur_bit, drive_idx;
  logic              sck_act, mosi_r;
  logic              need_tx, load_ok, lead, trail, sample, drive, last_ph;

  // named internal events
  assign need_tx   = tx_taken < tx_len;
  assign load_ok   = (state == ST_LOAD) && (!need_tx || !tx_empty);
  assign tx_pop    = load_ok && need_tx;
  assign next_byte = need_tx ? tx_data : '0;
  assign cur_bit   = phase[PH_W-1:1];
  assign lead      = (state == ST_RUN) && tick && !phase[0];
  assign trail     = (state == ST_RUN) && tick && phase[0];
  assign last_ph   = trail && (phase == LAST_PH);
  assign sample    = cpha ? trail : lead;
  assign drive     = cpha ? lead : (trail && !last_ph);
  assign drive_idx = cpha ? cur_bit : cur_bit + IDX_W'(1);

  assign rx_push    = (state == ST_FIN) && !discard && !rx_full;
  assign ovf_evt    = (state == ST_FIN) && !discard && rx_full;
  assign rx_data    = rxb;
  assign burst_done = (state == ST_DONE);
  assign busy       = (state != ST_IDLE);
  assign sck_o      = cpol ^ sck_act;
  assign mosi_o     = mosi_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      byte_cnt <= '0;
      tx_taken <= '0;
      txb      <= '0;
      rxb      <= '0;
      phase    <= '0;
      sck_act  <= 1'b0;
      mosi_r   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          byte_cnt <= '0;
          tx_taken <= '0;
          state    <= (burst_len == '0) ? ST_DONE : ST_LOAD;
        end
        ST_LOAD: if (load_ok) begin
          txb     <= next_byte;
          rxb     <= '0;
          phase   <= '0;
          sck_act <= 1'b0;
          if (need_tx) tx_taken <= tx_taken + CNT_W'(1);
          if (!cpha) mosi_r <= next_byte[wire_bit(lsb_first, '0)];
          state   <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          sck_act <= ~sck_act;
          phase   <= phase + PH_W'(1);
          if (sample) rxb[wire_bit(lsb_first, cur_bit)] <= miso_i;
          if (drive)  mosi_r <= txb[wire_bit(lsb_first, drive_idx)];
          if (last_ph) state <= ST_FIN;
        end
        ST_FIN: begin
          byte_cnt <= byte_cnt + CNT_W'(1);
          state    <= (byte_cnt + CNT_W'(1) == burst_len) ? ST_DONE : ST_LOAD;
        end
        ST_DONE: begin
          mosi_r <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_o == cpol));

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !tick) |=> $stable(mosi_o));

  // R5
  tx_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (tx_taken <= tx_len));

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (byte_cnt == burst_len));

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned CS_W   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              manual,
  input  logic              man_level,
  input  logic              act_high,
  input  logic [CS_W-1:0]   idx,
  output logic [NUM_CS-1:0] cs_o
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic chosen;
    assign chosen  = (idx == CS_W'(i));
    assign cs_o[i] = !chosen ? ~act_high :
                     manual  ? man_level :
                     busy    ? act_high  : ~act_high;
  end

  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ {NUM_CS{~act_high}}));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned NUM_CS     = 4,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_tick,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_o,
  output logic              irq_o
);
  localparam int unsigned FILL_W = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned CS_W   = $clog2(NUM_CS);

  // control fields
  logic cpha, cpol, act_high, cs_man, cs_lvl, discard, lsb_first;
  logic [CS_W-1:0]  cs_idx;
  logic             ien_ovf, ien_done, stat_ovf, stat_done;
  logic [CNT_W-1:0] burst_len, tx_len, single_len;

  // named strobes
  logic wr_ctl, wr_sta, wr_fctl, start_req, tx_flush, rx_flush, tx_push, rx_pop;
  logic busy, burst_done, ovf_evt;
  logic tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
  logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
  logic [FILL_W-1:0] tx_cnt, rx_cnt;
  logic unused_wbits;

  assign wr_ctl    = reg_we && (reg_addr == A_CTL);
  assign wr_sta    = reg_we && (reg_addr == A_STA);
  assign wr_fctl   = reg_we && (reg_addr == A_FCTL);
  assign start_req = wr_ctl && reg_wdata[B_GO] && !busy;
  assign tx_flush  = wr_fctl && reg_wdata[B_TXRST];
  assign rx_flush  = wr_fctl && reg_wdata[B_RXRST];
  assign tx_push   = reg_we && (reg_addr == A_TXD);
  assign rx_pop    = reg_re && (reg_addr == A_RXD);
  assign unused_wbits = ^reg_wdata[30:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cpha, cpol, act_high, cs_man, cs_lvl, discard, lsb_first} <= '0;
      cs_idx     <= '0;
      ien_ovf    <= 1'b0;
      ien_done   <= 1'b0;
      stat_ovf   <= 1'b0;
      stat_done  <= 1'b0;
      burst_len  <= '0;
      tx_len     <= '0;
      single_len <= '0;
    end else begin
      if (wr_ctl) begin
        cpha      <= reg_wdata[B_CPHA];
        cpol      <= reg_wdata[B_CPOL];
        act_high  <= reg_wdata[B_ACTHI];
        cs_idx    <= reg_wdata[B_CSIDX +: CS_W];
        cs_man    <= reg_wdata[B_CSMAN];
        cs_lvl    <= reg_wdata[B_CSLVL];
        discard   <= reg_wdata[B_DISC];
        lsb_first <= reg_wdata[B_LSB];
      end
      if (reg_we && reg_addr == A_IEN) begin
        ien_ovf  <= reg_wdata[B_OVF];
        ien_done <= reg_wdata[B_DONE];
      end
      if (reg_we && reg_addr == A_BLEN) burst_len  <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_addr == A_TLEN) tx_len     <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_addr == A_SLEN) single_len <= reg_wdata[CNT_W-1:0];
      // a new event wins over a clear in the same cycle
      stat_done <= (stat_done && !(wr_sta && reg_wdata[B_DONE])) || burst_done;
      stat_ovf  <= (stat_ovf  && !(wr_sta && reg_wdata[B_OVF]))  || ovf_evt;
    end
  end

  assign irq_o = (stat_done && ien_done) || (stat_ovf && ien_ovf);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTL: begin
        reg_rdata[B_CPHA]            = cpha;
        reg_rdata[B_CPOL]            = cpol;
        reg_rdata[B_ACTHI]           = act_high;
        reg_rdata[B_CSIDX +: CS_W]   = cs_idx;
        reg_rdata[B_CSMAN]           = cs_man;
        reg_rdata[B_CSLVL]           = cs_lvl;
        reg_rdata[B_DISC]            = discard;
        reg_rdata[B_LSB]             = lsb_first;
        reg_rdata[B_GO]              = busy;
      end
      A_IEN: begin
        reg_rdata[B_OVF]  = ien_ovf;
        reg_rdata[B_DONE] = ien_done;
      end
      A_STA: begin
        reg_rdata[B_OVF]  = stat_ovf;
        reg_rdata[B_DONE] = stat_done;
      end
      A_FSTA: begin
        reg_rdata[FILL_W-1:0]       = rx_cnt;
        reg_rdata[B_TXFIL +: FILL_W] = tx_cnt;
      end
      A_BLEN:  reg_rdata[CNT_W-1:0]  = burst_len;
      A_TLEN:  reg_rdata[CNT_W-1:0]  = tx_len;
      A_SLEN:  reg_rdata[CNT_W-1:0]  = single_len;
      A_RXD:   reg_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
      default: reg_rdata = '0;
    endcase
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .wdata(reg_wdata[BYTE_W-1:0]),
    .pop(tx_pop), .rdata(tx_head),
    .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head),
    .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start_req),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .discard(discard),
    .burst_len(burst_len), .tx_len(tx_len), .tick(sck_tick),
    .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_byte),
    .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o),
    .busy(busy), .burst_done(burst_done), .ovf_evt(ovf_evt)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .manual(cs_man),
    .man_level(cs_lvl), .act_high(act_high), .idx(cs_idx), .cs_o(cs_o)
  );

  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> stat_done);

  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_ovf);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> busy);

  // R5
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_pop && !tx_flush) |=> tx_full);

endmodule

// File: tb/spi_burst_master_bench.sv
`timescale 1ns/1ps
module spi_burst_master_bench;
  localparam logic [3:0] A_CTL = 4'd0, A_IEN = 4'd1, A_STA = 4'd2, A_FCTL = 4'd3,
                         A_FSTA = 4'd4, A_BLEN = 4'd5, A_TLEN = 4'd6, A_SLEN = 4'd7,
                         A_TXD = 4'd8, A_RXD = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck_tick = 1'b0;
  logic        sck_o, mosi_o, miso_i, irq_o;
  logic [3:0]  cs_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign miso_i = mosi_o;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_tick(sck_tick), .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o),
    .cs_o(cs_o), .irq_o(irq_o)
  );

  // wire monitor: decodes MOSI MSB-first on the programmed sampling edge
  bit         armed = 0;
  bit         m_cpol = 0, m_cpha = 0;
  logic       prev_sck = 1'b0;
  logic [7:0] mon_sh = '0;
  int         mon_bits = 0;
  int         mon_n = 0;
  logic [7:0] mon_buf [0:255];

  always @(negedge clk) begin
    if (!armed) mon_bits = 0;
    else if (sck_o !== prev_sck) begin
      if ((sck_o != m_cpol) == !m_cpha) begin
        mon_sh = {mon_sh[6:0], mosi_o};
        mon_bits++;
        if (mon_bits == 8) begin
          mon_buf[mon_n % 256] = mon_sh;
          mon_n++;
          mon_bits = 0;
        end
      end
    end
    prev_sck = sck_o;
  end

  initial begin
    forever begin
      @(negedge clk);
      sck_tick = ~sck_tick;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  function automatic logic [7:0] wire_byte(input logic [7:0] b, input bit lsb);
    return lsb ? rev8(b) : b;
  endfunction

  function automatic logic [31:0] mk_ctl(input bit cpol, cpha, lsb, act,
                                         input logic [1:0] idx, input bit disc);
    return 32'(cpha) | (32'(cpol) << 1) | (32'(act) << 2) | (32'(idx) << 4) |
           (32'(disc) << 8) | (32'(lsb) << 12);
  endfunction

  function automatic logic [3:0] exp_cs(input logic [1:0] idx, input bit act, input bit on);
    logic [3:0] v;
    v = {4{~act}};
    if (on) v[idx] = act;
    return v;
  endfunction

  function automatic logic [31:0] exp_fsta(input int rx, input int tx);
    return (32'(tx) << 16) | 32'(rx);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input bit pop, output logic [31:0] d);
    reg_addr = a; reg_re = pop;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'hFFFF_FFFF;
    for (int i = 0; i < 20000; i++) begin
      rd(A_CTL, 0, v);
      if (!v[31]) break;
    end
    check("R2 start bit self-clears", 32'(v[31]), 0);
  endtask

  task automatic run_burst(input bit cpol, cpha, lsb, act, input logic [1:0] idx,
                           input int len, input int tl, input int extra, input bit disc);
    logic [7:0]  txq [0:15];
    logic [31:0] cfg, v;
    logic [7:0]  e;
    int          base;
    wr(A_FCTL, 32'h8000_8000);
    for (int k = 0; k < tl + extra; k++) begin
      txq[k] = 8'($urandom);
      wr(A_TXD, 32'(txq[k]));
    end
    wr(A_BLEN, 32'(len));
    wr(A_TLEN, 32'(tl));
    wr(A_STA, 32'hFFFF_FFFF);
    wr(A_IEN, 32'h1000);
    armed = 0; m_cpol = cpol; m_cpha = cpha;
    cfg = mk_ctl(cpol, cpha, lsb, act, idx, disc);
    wr(A_CTL, cfg);
    repeat (2) @(negedge clk);
    base = mon_n; armed = 1;
    wr(A_CTL, cfg | 32'h8000_0000);
    rd(A_CTL, 0, v);
    check("R2 busy after start", 32'(v[31]), 1);
    check("R10 chosen line active in burst", 32'(cs_o), 32'(exp_cs(idx, act, 1)));
    wait_idle();
    armed = 0;
    check("R7 irq on done", 32'(irq_o), 1);
    rd(A_STA, 0, v);
    check("R7 done flag", v, 32'h1000);
    check("R3 bytes on wire", mon_n - base, len);
    for (int k = 0; k < len; k++) begin
      e = (k < tl) ? txq[k] : 8'h00;
      check("R4 R5 wire byte", 32'(mon_buf[(base + k) % 256]), 32'(wire_byte(e, lsb)));
    end
    rd(A_FSTA, 0, v);
    check("R5 R6 fill counts", v, exp_fsta(disc ? 0 : len, extra));
    if (!disc) begin
      for (int k = 0; k < len; k++) begin
        e = (k < tl) ? txq[k] : 8'h00;
        rd(A_RXD, 1, v);
        check("R3 received byte", v, 32'(e));
      end
    end
    wr(A_STA, 32'h1000);
    check("R7 w1c clears irq", 32'(irq_o), 0);
    check("R10 line idle after burst", 32'(cs_o), 32'(exp_cs(idx, act, 0)));
  endtask

  initial begin
    logic [31:0] v;
    int          seed_probe;
    seed_probe = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sck low", 32'(sck_o), 0);
    check("R1 cs inactive", 32'(cs_o), 32'hF);
    check("R1 irq low", 32'(irq_o), 0);
    rd(A_CTL, 0, v);  check("R1 ctl zero", v, 0);
    rd(A_STA, 0, v);  check("R1 status zero", v, 0);
    rd(A_FSTA, 0, v); check("R1 fifo status zero", v, 0);

    // R3 idle polarity
    wr(A_CTL, 32'h2);
    check("R3 idle high", 32'(sck_o), 1);
    wr(A_CTL, 32'h0);
    check("R3 idle low", 32'(sck_o), 0);

    // R10 manual chip select
    wr(A_CTL, 32'h0000_0060);
    check("R10 manual low", 32'(cs_o), 32'hB);
    wr(A_CTL, 32'h0000_00E0);
    check("R10 manual high", 32'(cs_o), 32'hF);
    wr(A_CTL, 32'h0000_00D4);
    check("R10 manual active-high", 32'(cs_o), 32'h2);
    wr(A_CTL, 32'h0);

    // R5 single-mode count storage
    wr(A_SLEN, 32'h00AB_CDEF);
    rd(A_SLEN, 0, v);
    check("R5 single count readback", v, 32'h00AB_CDEF);

    // directed bursts
    run_burst(0, 0, 0, 0, 2'd0, 4, 2, 1, 0);
    run_burst(1, 1, 1, 1, 2'd3, 3, 3, 0, 0);
    run_burst(0, 1, 0, 0, 2'd1, 3, 0, 2, 1);

    // random bursts
    for (int it = 0; it < 12; it++) begin
      int len, tl;
      len = 1 + int'($urandom % 6);
      tl  = int'($urandom % (len + 1));
      run_burst(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                2'($urandom), len, tl, int'($urandom % 3), ($urandom % 4) == 0);
    end

    // R2 zero-length burst completes at once
    wr(A_STA, 32'hFFFF_FFFF);
    wr(A_BLEN, 32'd0);
    wr(A_CTL, 32'h8000_0000);
    wait_idle();
    rd(A_STA, 0, v);
    check("R2 zero length done", v, 32'h1000);

    // R7 masked interrupt, then enabled, then clear-all
    wr(A_FCTL, 32'h8000_8000);
    wr(A_STA, 32'hFFFF_FFFF);
    wr(A_IEN, 32'h0);
    wr(A_BLEN, 32'd1);
    wr(A_TLEN, 32'd0);
    wr(A_CTL, 32'h8000_0000);
    wait_idle();
    check("R7 masked irq", 32'(irq_o), 0);
    rd(A_STA, 0, v);
    check("R7 flag set while masked", v, 32'h1000);
    wr(A_IEN, 32'h1000);
    check("R7 irq when enabled", 32'(irq_o), 1);
    wr(A_STA, 32'hFFFF_FFFF);
    rd(A_STA, 0, v);
    check("R7 clear all", v, 0);

    // R8 R9 receive overflow past the FIFO depth
    wr(A_FCTL, 32'h8000_8000);
    wr(A_IEN, 32'h100);
    wr(A_BLEN, 32'd130);
    wr(A_TLEN, 32'd0);
    wr(A_CTL, 32'h8000_0000);
    wait_idle();
    rd(A_FSTA, 0, v);
    check("R9 rx fill reports 128", v, exp_fsta(128, 0));
    rd(A_STA, 0, v);
    check("R8 overflow flag", 32'(v[8]), 1);
    check("R8 overflow irq", 32'(irq_o), 1);
    wr(A_FCTL, 32'h0000_8000);
    rd(A_FSTA, 0, v);
    check("R9 rx reset", v, 0);
    wr(A_STA, 32'hFFFF_FFFF);
    check("R8 overflow cleared", 32'(irq_o), 0);

    // R9 transmit FIFO fill and reset
    for (int k = 0; k < 130; k++) wr(A_TXD, 32'(k));
    rd(A_FSTA, 0, v);
    check("R9 tx fill reports 128", v, exp_fsta(0, 128));
    wr(A_FCTL, 32'h8000_0000);
    rd(A_FSTA, 0, v);
    check("R9 tx reset", v, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule